// File: doc/BRIEF.md
# Hamming ECC syndrome corrector

This block checks flash sectors protected by a 3-byte Hamming code. For each sector it receives two codes: the code read back from the spare area and the code the datapath computed over the data just read. It does not compute either code. The two codes are unpacked into twelve even/odd parity-term pairs and XORed to form a 24-bit syndrome. The number of set syndrome bits decides the outcome. When the outcome is a single-bit data error, the odd-term bits of the syndrome give the byte offset and the bit index of the bad bit within the 512-byte sector.

A job covers a page of `SECTORS` sectors, four by default for a 2048-byte page. The sectors are handled strictly one after another. Each sector produces one report carrying its outcome, offset and bit. When repair is enabled, the block flips the bad bit in an external sector buffer through a read-modify-write port with a read latency of one cycle. The last report also carries the page outcome and the number of sectors that were corrected.

Top module: `ecc_page_corrector`

## Requirements
- R1: Each 3-byte code `{byte2,byte1,byte0}` (byte0 in bits 7:0) maps to parity terms as follows, with term 2k the even term and term 2k+1 the odd term of pair k. For k<8, even pair k is byte0 bit k and odd pair k is byte1 bit k. For 8≤k<12, even pair k is byte2 bit k-8 and odd pair k is byte2 bit k-4. The syndrome is the XOR of the two term vectors.
- R2: A syndrome with no set bit reports result code 2'b00 (no error) and causes no buffer access.
- R3: A syndrome with exactly one set bit is an error in the code itself: it reports 2'b00 and leaves the data untouched.
- R4: A syndrome with exactly 12 set bits reports 2'b01 (corrected). The bit index is syndrome bits {5,3,1}, most significant first. The byte offset is syndrome bits {23,21,...,7}, with bit 23 as the MSB.
- R5: Any other set-bit count (2 to 11, or 13 to 24) reports 2'b11 (uncorrectable, -1) and causes no buffer access.
- R6: A stored code of 24'hFFFFFF marks an erased sector and reports 2'b00 with no buffer access, whatever the computed code.
- R7: With repair enabled, a corrected sector reads buffer address `sector*512+offset`. In the next cycle it writes that byte back XORed with `1<<bit` to the same address. That is exactly one read and one write per corrected sector.
- R8: With repair disabled, the buffer port stays idle.
- R9: Sectors are reported in order 0 to SECTORS-1, with `sec_idx_o` naming each one. `page_done_o` comes with the last report. That report carries the count of corrected sectors and a page result: 2'b11 if any sector was uncorrectable, else 2'b01 if any was corrected, else 2'b00.
- R10: The first report is valid after the second rising edge counting the edge that samples `start_i`. Each later report follows the previous one by two edges. A repaired sector adds two edges. `busy_o` drops one edge after the last report.
- R11: `start_i` and changes on the code and repair inputs have no effect while `busy_o` is high.
- R12: After reset `busy_o`, `sec_valid_o`, `page_done_o`, `mem_re_o`, `mem_we_o` and `corr_cnt_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a page job (sampled when idle) |
| fix_en_i | input | 1 | Enable in-buffer repair for this job |
| stored_codes_i | input | 24*SECTORS | Stored codes, sector s in bits 24s+23:24s |
| calc_codes_i | input | 24*SECTORS | Computed codes, same packing |
| busy_o | output | 1 | Job in progress |
| sec_valid_o | output | 1 | Sector report valid |
| sec_idx_o | output | SEC_W | Sector being reported |
| sec_result_o | output | 2 | Sector result: 00 none, 01 corrected, 11 uncorrectable |
| sec_ofs_o | output | 9 | Byte offset of the bad bit |
| sec_bit_o | output | 3 | Bit index of the bad bit |
| page_done_o | output | 1 | Last sector report of the job |
| page_result_o | output | 2 | Page result, same encoding |
| corr_cnt_o | output | CNT_W | Corrected sectors so far in this job |
| mem_re_o | output | 1 | Buffer read strobe |
| mem_we_o | output | 1 | Buffer write strobe |
| mem_addr_o | output | ADDR_W | Buffer byte address |
| mem_wdata_o | output | 8 | Repaired byte |
| mem_rdata_i | input | 8 | Buffer read data, one cycle after the read strobe |

## Verification
Every sector report is due at a fixed edge: two edges after the start edge or after the previous report, plus two edges when a repair runs. The bench therefore counts edges from the start pulse, samples each negedge on the way, and requires `sec_valid_o` to be low until the predicted edge and high exactly there. The idle state is due one edge after the final report. The buffer contents and the read and write counts are compared once that idle state is reached, so a late or missing write is caught.

// File: rtl/ecc_corr_pkg.sv
package ecc_corr_pkg;

  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned CODE_BYTES   = 3;
  localparam int unsigned CODE_W       = BYTE_W * CODE_BYTES;
  localparam int unsigned TERM_PAIRS   = CODE_W / 2;
  localparam int unsigned BIT_IDX_W    = $clog2(BYTE_W);
  localparam int unsigned OFS_W        = TERM_PAIRS - BIT_IDX_W;
  localparam int unsigned SECTOR_BYTES = 1 << OFS_W;
  localparam int unsigned HIGH_TERMS   = TERM_PAIRS - BYTE_W;
  localparam int unsigned POP_W        = $clog2(CODE_W + 1);
  localparam int unsigned CORR_WEIGHT  = TERM_PAIRS;

  typedef enum logic [1:0] {
    RES_NONE   = 2'b00,
    RES_CORR   = 2'b01,
    RES_UNCORR = 2'b11
  } ecc_res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_READ,
    ST_WRITE,
    ST_REPORT
  } ecc_st_e;

  function automatic ecc_res_e res_merge(input ecc_res_e a, input ecc_res_e b);
    if (a == RES_UNCORR || b == RES_UNCORR) return RES_UNCORR;
    if (a == RES_CORR || b == RES_CORR) return RES_CORR;
    return RES_NONE;
  endfunction

endpackage

// File: rtl/ecc_term_unpack.sv
module ecc_term_unpack
  import ecc_corr_pkg::*;
(
  input  logic [CODE_W-1:0] raw_i,
  output logic [CODE_W-1:0] term_o
);

  // term 2k = even term of pair k, term 2k+1 = odd term of pair k
  for (genvar k = 0; k < TERM_PAIRS; k++) begin : g_pair
    if (k < BYTE_W) begin : g_lo
      assign term_o[2*k]   = raw_i[k];
      assign term_o[2*k+1] = raw_i[BYTE_W + k];
    end else begin : g_hi
      assign term_o[2*k]   = raw_i[2*BYTE_W + (k - BYTE_W)];
      assign term_o[2*k+1] = raw_i[2*BYTE_W + HIGH_TERMS + (k - BYTE_W)];
    end
  end

endmodule

// File: rtl/ecc_syn_classify.sv
module ecc_syn_classify
  import ecc_corr_pkg::*;
(
  input  logic [CODE_W-1:0]    stored_term_i,
  input  logic [CODE_W-1:0]    calc_term_i,
  input  logic                 erased_i,
  output ecc_res_e             res_o,
  output logic [OFS_W-1:0]     ofs_o,
  output logic [BIT_IDX_W-1:0] bit_o
);

  logic [CODE_W-1:0]     syn;
  logic [TERM_PAIRS-1:0] odd;
  logic [POP_W-1:0]      pop;

  assign syn = stored_term_i ^ calc_term_i;

  for (genvar k = 0; k < TERM_PAIRS; k++) begin : g_odd
    assign odd[k] = syn[2*k+1];
  end

  always_comb begin
    pop = '0;
    for (int i = 0; i < CODE_W; i++) pop = pop + POP_W'(syn[i]);
  end

  always_comb begin
    if (erased_i || pop <= POP_W'(1))   res_o = RES_NONE;
    else if (pop == POP_W'(CORR_WEIGHT)) res_o = RES_CORR;
    else                                 res_o = RES_UNCORR;
  end

  assign bit_o = odd[BIT_IDX_W-1:0];
  assign ofs_o = odd[TERM_PAIRS-1:BIT_IDX_W];

endmodule

// File: rtl/ecc_fix_port.sv
module ecc_fix_port
  import ecc_corr_pkg::*;
#(
  parameter int unsigned SEC_W  = 2,
  parameter int unsigned ADDR_W = 11
) (
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [SEC_W-1:0]     sec_i,
  input  logic [OFS_W-1:0]     ofs_i,
  input  logic [BIT_IDX_W-1:0] bit_i,
  input  logic [BYTE_W-1:0]    rdata_i,
  output logic                 re_o,
  output logic                 we_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [BYTE_W-1:0]    wdata_o
);

  assign re_o    = rd_i;
  assign we_o    = wr_i;
  assign addr_o  = (ADDR_W'(sec_i) << OFS_W) | ADDR_W'(ofs_i);
  assign wdata_o = rdata_i ^ (BYTE_W'(1) << bit_i);

endmodule

// File: rtl/ecc_page_corrector.sv
module ecc_page_corrector
  import ecc_corr_pkg::*;
#(
  parameter  int unsigned SECTORS = 4,
  localparam int unsigned SEC_W   = (SECTORS > 1) ? $clog2(SECTORS) : 1,
  localparam int unsigned ADDR_W  = $clog2(SECTORS * SECTOR_BYTES),
  localparam int unsigned CNT_W   = $clog2(SECTORS + 1),
  localparam int unsigned ALL_W   = SECTORS * CODE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 fix_en_i,
  input  logic [ALL_W-1:0]     stored_codes_i,
  input  logic [ALL_W-1:0]     calc_codes_i,
  output logic                 busy_o,
  output logic                 sec_valid_o,
  output logic [SEC_W-1:0]     sec_idx_o,
  output logic [1:0]           sec_result_o,
  output logic [OFS_W-1:0]     sec_ofs_o,
  output logic [BIT_IDX_W-1:0] sec_bit_o,
  output logic                 page_done_o,
  output logic [1:0]           page_result_o,
  output logic [CNT_W-1:0]     corr_cnt_o,
  output logic                 mem_re_o,
  output logic                 mem_we_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic [BYTE_W-1:0]    mem_wdata_o,
  input  logic [BYTE_W-1:0]    mem_rdata_i
);

  ecc_st_e                state_q;
  logic [SEC_W-1:0]       sec_q;
  logic                   fix_en_q;
  logic [ALL_W-1:0]       stored_q;
  logic [ALL_W-1:0]       calc_q;
  ecc_res_e               res_q;
  ecc_res_e               page_res_q;
  logic [OFS_W-1:0]       ofs_q;
  logic [BIT_IDX_W-1:0]   bit_q;
  logic [CNT_W-1:0]       cnt_q;

  logic [CODE_W-1:0]      cur_stored, cur_calc;
  logic [CODE_W-1:0]      stored_term, calc_term;
  logic                   erased;
  ecc_res_e               cls_res;
  logic [OFS_W-1:0]       cls_ofs;
  logic [BIT_IDX_W-1:0]   cls_bit;
  logic                   last_sec;

  assign cur_stored = stored_q[sec_q*CODE_W +: CODE_W];
  assign cur_calc   = calc_q[sec_q*CODE_W +: CODE_W];
  assign erased     = (cur_stored == '1);
  assign last_sec   = (sec_q == SEC_W'(SECTORS - 1));

  ecc_term_unpack u_unpack_stored (
    .raw_i  (cur_stored),
    .term_o (stored_term)
  );

  ecc_term_unpack u_unpack_calc (
    .raw_i  (cur_calc),
    .term_o (calc_term)
  );

  ecc_syn_classify u_classify (
    .stored_term_i (stored_term),
    .calc_term_i   (calc_term),
    .erased_i      (erased),
    .res_o         (cls_res),
    .ofs_o         (cls_ofs),
    .bit_o         (cls_bit)
  );

  ecc_fix_port #(
    .SEC_W  (SEC_W),
    .ADDR_W (ADDR_W)
  ) u_fix_port (
    .rd_i    (state_q == ST_READ),
    .wr_i    (state_q == ST_WRITE),
    .sec_i   (sec_q),
    .ofs_i   (ofs_q),
    .bit_i   (bit_q),
    .rdata_i (mem_rdata_i),
    .re_o    (mem_re_o),
    .we_o    (mem_we_o),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sec_q      <= '0;
      fix_en_q   <= 1'b0;
      stored_q   <= '0;
      calc_q     <= '0;
      res_q      <= RES_NONE;
      page_res_q <= RES_NONE;
      ofs_q      <= '0;
      bit_q      <= '0;
      cnt_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            stored_q   <= stored_codes_i;
            calc_q     <= calc_codes_i;
            fix_en_q   <= fix_en_i;
            sec_q      <= '0;
            cnt_q      <= '0;
            page_res_q <= RES_NONE;
            state_q    <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          res_q      <= cls_res;
          ofs_q      <= cls_ofs;
          bit_q      <= cls_bit;
          page_res_q <= res_merge(page_res_q, cls_res);
          if (cls_res == RES_CORR) cnt_q <= cnt_q + CNT_W'(1);
          state_q <= (cls_res == RES_CORR && fix_en_q) ? ST_READ : ST_REPORT;
        end
        ST_READ:  state_q <= ST_WRITE;
        ST_WRITE: state_q <= ST_REPORT;
        ST_REPORT: begin
          if (last_sec) begin
            state_q <= ST_IDLE;
          end else begin
            sec_q   <= sec_q + SEC_W'(1);
            state_q <= ST_EVAL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign sec_valid_o   = (state_q == ST_REPORT);
  assign page_done_o   = sec_valid_o && last_sec;
  assign sec_idx_o     = sec_q;
  assign sec_result_o  = res_q;
  assign sec_ofs_o     = ofs_q;
  assign sec_bit_o     = bit_q;
  assign page_result_o = page_res_q;
  assign corr_cnt_o    = cnt_q;

endmodule

// File: rtl/ecc_page_corrector_chk.sv
module ecc_page_corrector_chk
  import ecc_corr_pkg::*;
#(
  parameter  int unsigned SECTORS = 4,
  localparam int unsigned SEC_W   = (SECTORS > 1) ? $clog2(SECTORS) : 1,
  localparam int unsigned ADDR_W  = $clog2(SECTORS * SECTOR_BYTES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              sec_valid_o,
  input logic [SEC_W-1:0]  sec_idx_o,
  input logic [1:0]        sec_result_o,
  input logic              page_done_o,
  input logic              mem_re_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [BYTE_W-1:0] mem_wdata_o,
  input logic [BYTE_W-1:0] mem_rdata_i,
  input logic              fix_en_q
);

  assert_rmw_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> mem_we_o && $stable(mem_addr_o));

  assert_one_flip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $countones(mem_wdata_o ^ mem_rdata_i) == 1);

  assert_write_then_corr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> sec_valid_o && sec_result_o == 2'b01);

  assert_quiet_no_fix_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fix_en_q |-> !mem_re_o && !mem_we_o);

  assert_done_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_done_o |-> sec_valid_o && sec_idx_o == SEC_W'(SECTORS - 1));

  assert_busy_from_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_valid_needs_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_valid_o |-> busy_o);

endmodule

bind ecc_page_corrector ecc_page_corrector_chk #(.SECTORS(SECTORS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .sec_valid_o (sec_valid_o),
  .sec_idx_o   (sec_idx_o),
  .sec_result_o(sec_result_o),
  .page_done_o (page_done_o),
  .mem_re_o    (mem_re_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdata_i (mem_rdata_i),
  .fix_en_q    (fix_en_q)
);

// File: tb/ecc_page_corrector_test.sv
module ecc_page_corrector_test;

  localparam int CLK_PERIOD = 10;
  localparam int SECTORS    = 4;
  localparam int CW         = 24;
  localparam int ADDR_W     = 11;
  localparam int MEM_N      = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic fix_en_i = 1'b0;
  logic [SECTORS*CW-1:0] stored_codes = '0;
  logic [SECTORS*CW-1:0] calc_codes = '0;
  logic busy, sec_valid, page_done, mem_re, mem_we;
  logic [1:0] sec_idx, sec_result, page_result;
  logic [8:0] sec_ofs;
  logic [2:0] sec_bit, corr_cnt;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [7:0] delta     [0:MEM_N-1];
  logic [7:0] exp_delta [0:MEM_N-1];
  int wr_cnt, rd_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_page_corrector #(.SECTORS(SECTORS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .fix_en_i(fix_en_i),
    .stored_codes_i(stored_codes), .calc_codes_i(calc_codes),
    .busy_o(busy), .sec_valid_o(sec_valid), .sec_idx_o(sec_idx),
    .sec_result_o(sec_result), .sec_ofs_o(sec_ofs), .sec_bit_o(sec_bit),
    .page_done_o(page_done), .page_result_o(page_result), .corr_cnt_o(corr_cnt),
    .mem_re_o(mem_re), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] init_byte(input int a);
    return 8'((a * 29 + 7) ^ (a >> 3));
  endfunction

  // sector buffer model, one-cycle read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_N; i++) delta[i] <= '0;
      wr_cnt <= 0;
      rd_cnt <= 0;
      mem_rdata <= '0;
    end else begin
      if (mem_re) begin
        mem_rdata <= init_byte(int'(mem_addr)) ^ delta[mem_addr];
        rd_cnt <= rd_cnt + 1;
      end
      if (mem_we) begin
        delta[mem_addr] <= mem_wdata ^ init_byte(int'(mem_addr));
        wr_cnt <= wr_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // term t -> raw code bit position (R1)
  function automatic int term_pos(input int t);
    int k;
    k = t / 2;
    if (k < 8) return (t % 2) ? 8 + k : k;
    return (t % 2) ? 20 + (k - 8) : 16 + (k - 8);
  endfunction

  function automatic logic [CW-1:0] terms_to_raw(input logic [CW-1:0] syn);
    logic [CW-1:0] r;
    r = '0;
    for (int t = 0; t < CW; t++) r[term_pos(t)] = syn[t];
    return r;
  endfunction

  function automatic logic [CW-1:0] ham_syn(input int a);
    logic [CW-1:0] s;
    for (int k = 0; k < 12; k++) begin
      s[2*k+1] = a[k];
      s[2*k]   = ~a[k];
    end
    return s;
  endfunction

  function automatic logic [CW-1:0] rotl(input logic [CW-1:0] v, input int n);
    logic [CW-1:0] r;
    r = v;
    for (int i = 0; i < n; i++) r = {r[CW-2:0], r[CW-1]};
    return r;
  endfunction

  task automatic exp_class(input logic [CW-1:0] syn, input bit erased,
                           output logic [1:0] res, output logic [8:0] ofs,
                           output logic [2:0] bt, output string tag);
    int pop;
    pop = 0;
    for (int i = 0; i < CW; i++) pop += int'(syn[i]);
    for (int k = 0; k < 3; k++) bt[k] = syn[2*k+1];
    for (int k = 0; k < 9; k++) ofs[k] = syn[2*(k+3)+1];
    if (erased)         begin res = 2'b00; tag = "R6"; end
    else if (pop == 0)  begin res = 2'b00; tag = "R2"; end
    else if (pop == 1)  begin res = 2'b00; tag = "R3"; end
    else if (pop == 12) begin res = 2'b01; tag = "R4"; end
    else                begin res = 2'b11; tag = "R5"; end
  endtask

  task automatic do_job(input logic [SECTORS*CW-1:0] calc_all,
                        input logic [SECTORS*CW-1:0] syn_all,
                        input logic [SECTORS-1:0] erase,
                        input bit fix, input bit hold);
    logic [1:0] e_res [SECTORS];
    logic [8:0] e_ofs [SECTORS];
    logic [2:0] e_bit [SECTORS];
    string      e_tag [SECTORS];
    logic [SECTORS*CW-1:0] st_all;
    logic [1:0] e_page;
    int wr0, rd0, nfix, ncorr, n, a;
    e_page = 2'b00;
    nfix = 0;
    ncorr = 0;
    for (int s = 0; s < SECTORS; s++) begin
      st_all[s*CW +: CW] = erase[s] ? 24'hFFFFFF
                         : calc_all[s*CW +: CW] ^ terms_to_raw(syn_all[s*CW +: CW]);
      exp_class(syn_all[s*CW +: CW], erase[s], e_res[s], e_ofs[s], e_bit[s], e_tag[s]);
      if (e_res[s] == 2'b11) e_page = 2'b11;
      else if (e_res[s] == 2'b01 && e_page == 2'b00) e_page = 2'b01;
      if (e_res[s] == 2'b01) ncorr++;
      if (e_res[s] == 2'b01 && fix) begin
        nfix++;
        a = s * 512 + int'(e_ofs[s]);
        exp_delta[a] = exp_delta[a] ^ (8'd1 << e_bit[s]);
      end
    end
    wr0 = wr_cnt;
    rd0 = rd_cnt;
    @(negedge clk);
    start_i = 1'b1;
    fix_en_i = fix;
    stored_codes = st_all;
    calc_codes = calc_all;
    for (int s = 0; s < SECTORS; s++) begin
      n = 2 + ((e_res[s] == 2'b01 && fix) ? 2 : 0);
      for (int i = 0; i < n; i++) begin
        @(posedge clk);
        @(negedge clk);
        if (s == 0 && i == 0) begin
          if (hold) begin
            stored_codes = ~st_all;
            calc_codes = calc_all ^ {SECTORS{24'h5A3C96}};
            fix_en_i = ~fix;
          end else begin
            start_i = 1'b0;
          end
        end
        if (i < n - 1)
          chk(sec_valid == 1'b0, "R10", "early report", longint'(sec_valid), 0);
      end
      chk(sec_valid == 1'b1, "R10", "report due", longint'(sec_valid), 1);
      chk(sec_idx == 2'(s), "R9", "sector order", longint'(sec_idx), s);
      chk(sec_result == e_res[s], hold ? "R11" : e_tag[s], "sector result",
          longint'(sec_result), longint'(e_res[s]));
      if (e_res[s] == 2'b01) begin
        chk(sec_ofs == e_ofs[s], "R1,R4", "byte offset", longint'(sec_ofs), longint'(e_ofs[s]));
        chk(sec_bit == e_bit[s], "R1,R4", "bit index", longint'(sec_bit), longint'(e_bit[s]));
      end
      if (s == SECTORS - 1) begin
        chk(page_done == 1'b1, "R9", "page done", longint'(page_done), 1);
        chk(page_result == e_page, "R9", "page result", longint'(page_result), longint'(e_page));
        chk(corr_cnt == 3'(ncorr), "R9", "corrected count", longint'(corr_cnt), ncorr);
      end else begin
        chk(page_done == 1'b0, "R9", "early page done", longint'(page_done), 0);
      end
    end
    start_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R10", "busy after last", longint'(busy), 0);
    chk(rd_cnt - rd0 == nfix, fix ? "R7" : "R8", "read count", rd_cnt - rd0, nfix);
    chk(wr_cnt - wr0 == nfix, fix ? "R7" : "R8", "write count", wr_cnt - wr0, nfix);
    for (int s = 0; s < SECTORS; s++) begin
      if (e_res[s] == 2'b01 && fix) begin
        a = s * 512 + int'(e_ofs[s]);
        chk(delta[a] == exp_delta[a], "R7", "repaired byte",
            longint'(delta[a]), longint'(exp_delta[a]));
      end
    end
  endtask

  initial begin
    logic [SECTORS*CW-1:0] c_all, s_all;
    for (int i = 0; i < MEM_N; i++) exp_delta[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R12", "reset busy", longint'(busy), 0);
    chk(sec_valid == 1'b0, "R12", "reset valid", longint'(sec_valid), 0);
    chk(page_done == 1'b0, "R12", "reset done", longint'(page_done), 0);
    chk(mem_re == 1'b0 && mem_we == 1'b0, "R12", "reset strobes",
        longint'({mem_re, mem_we}), 0);
    chk(corr_cnt == 3'd0, "R12", "reset count", longint'(corr_cnt), 0);

    // R1 R4 R7 R8: every data bit position in a sector
    for (int j = 0; j < 1024; j++) begin
      for (int s = 0; s < SECTORS; s++) begin
        c_all[s*CW +: CW] = 24'(j * 40503 + s * 977 + 12345);
        s_all[s*CW +: CW] = ham_syn(j * 4 + s);
      end
      do_job(c_all, s_all, '0, (j % 2) == 0, 1'b0);
    end

    // R2 R3 R4 R5: every syndrome weight
    for (int w = 0; w <= CW; w++) begin
      for (int s = 0; s < SECTORS; s++) begin
        c_all[s*CW +: CW] = 24'(w * 7919 + s * 131);
        s_all[s*CW +: CW] = rotl(24'((64'd1 << w) - 1), s * 5);
      end
      do_job(c_all, s_all, '0, 1'b1, 1'b0);
    end

    // R3: each single syndrome bit
    for (int j = 0; j < CW / SECTORS; j++) begin
      for (int s = 0; s < SECTORS; s++) begin
        c_all[s*CW +: CW] = 24'(j * 3001 + s);
        s_all[s*CW +: CW] = 24'(1) << (j * SECTORS + s);
      end
      do_job(c_all, s_all, '0, 1'b1, 1'b0);
    end

    // R6: erased sectors, all and mixed
    for (int s = 0; s < SECTORS; s++) begin
      c_all[s*CW +: CW] = 24'(s * 55555 + 1);
      s_all[s*CW +: CW] = (s % 2) ? 24'h000007 : ham_syn(300 + s);
    end
    do_job(c_all, s_all, 4'b1111, 1'b1, 1'b0);
    do_job(c_all, s_all, 4'b0101, 1'b1, 1'b0);
    c_all = '0;
    do_job(c_all, s_all, 4'b1111, 1'b1, 1'b0);

    // R9: mixed page outcome
    for (int s = 0; s < SECTORS; s++) c_all[s*CW +: CW] = 24'(s * 8191 + 99);
    s_all[0*CW +: CW] = ham_syn(100);
    s_all[1*CW +: CW] = 24'h000013;
    s_all[2*CW +: CW] = 24'h000000;
    s_all[3*CW +: CW] = ham_syn(4000);
    do_job(c_all, s_all, '0, 1'b1, 1'b0);

    // R11: start held and inputs changed during the job
    do_job(c_all, s_all, '0, 1'b1, 1'b1);
    do_job(c_all, s_all, '0, 1'b0, 1'b1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R10 watchdog: got %0h expected %0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule